// File: doc/BRIEF.md
# Data Access Protection Checker

This block sits beside a data load/store path and judges every data access against a small table of protection entries. Each entry holds a page base address and an attribute byte. The attribute byte sets the page size, validity, the user and supervisor permissions, a dirty flag and a flag that limits the page to address generator 0. Software programs the table and a global enable through a simple word-addressed register port. For every access the block takes the address, the direction, the privilege level and the generator identifier. In the same cycle it returns either a clean pass, a protection exception with its cause code, or a miss/multi-hit indication.

When an access faults, the clock edge at which it is presented latches the faulting address and a status word. The status word records direction, generator, privilege level and a one-hot marker of the matching entry. Both registers keep their values until the next fault. An exception handler reads them through the register port, repairs the entry and retries the access. Address misses are reported on their own output so that a separate translation path can handle them. This block does not treat them as protection faults.

Top module: `dprot_checker`

## Requirements
- R1: An entry matches when its valid bit (attribute bit 0) is set and the access address equals the base address in every bit above the page offset. Attribute bits [7:6] select the page size: 0 = 1 KB, 1 = 4 KB, 2 = 1 MB, 3 = 4 MB.
- R2: A supervisor write to a matching entry faults unless the supervisor-write bit (attribute bit 3) is set. Supervisor reads are never refused by permissions.
- R3: A user write faults unless the user read/write bit (attribute bit 2) is set.
- R4: A user read faults unless the user read-only bit (attribute bit 1) or the user read/write bit is set.
- R5: A write to an entry whose dirty bit (attribute bit 4) is clear faults even when the write permission is granted. Reads are unaffected by the dirty bit.
- R6: When the generator-0-only bit (attribute bit 5) is set, an access with `acc_gen` = 1 faults and an access with `acc_gen` = 0 is judged by the other rules only.
- R7: `acc_fault` is combinational from the access inputs. While it is high `acc_cause` is 0x23, and otherwise `acc_cause` is 0.
- R8: At the rising edge where a faulting access is presented, the fault-address register (offset 0x21) takes the access address. It keeps that value across non-faulting accesses and idle cycles until the next fault.
- R9: The fault-status register (offset 0x22) is captured with the fault address. Bits [15:0] hold a one-hot marker of the matching entry, bit 16 = 1 for a write, bit 17 = the generator, and bit 18 = 1 for supervisor.
- R10: A valid, enabled access that matches no entry or more than one entry raises `acc_miss`, never raises `acc_fault`, and leaves the fault registers untouched.
- R11: Checking is active only while the enable bit (bit 0 of the control register at offset 0x20) is set. While it is clear, neither `acc_fault` nor `acc_miss` is raised.
- R12: Register map: base address of entry i at offset i, attribute of entry i at offset 0x10+i, control at 0x20. All are writable and all read back on `cfg_rdata` one clock after `cfg_addr` is presented. Synchronous reset clears the table, the enable bit and both fault registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 6 | Register word offset for write and read |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Registered read data for the offset of the previous cycle |
| acc_valid | input | 1 | A data access is presented this cycle |
| acc_addr | input | 32 | Data address of the access |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_supv | input | 1 | 1 = supervisor, 0 = user |
| acc_gen | input | 1 | Address generator issuing the access (0 or 1) |
| acc_fault | output | 1 | Protection exception for the presented access |
| acc_cause | output | 6 | Exception cause code, 0x23 on a fault |
| acc_miss | output | 1 | No matching entry, or more than one |

## Verification
The hardest situation to reach from the ports is a multi-hit: two valid entries whose pages overlap. The stimulus first builds a table of disjoint pages and walks a vector table across every permission path. It then programs a larger page over an existing one, so that a user write that would otherwise fault shows up only as a miss, and it confirms through the register port that the fault registers kept their earlier content. Fault capture is checked by reading both fault registers after faults of different direction, generator and privilege.

// File: rtl/dprot_pkg.sv
package dprot_pkg;

  // attribute byte layout
  localparam int ATTR_W    = 8;
  localparam int A_VALID   = 0;
  localparam int A_UREAD   = 1;
  localparam int A_URW     = 2;
  localparam int A_SWRITE  = 3;
  localparam int A_DIRTY   = 4;
  localparam int A_GEN0    = 5;
  localparam int A_SIZE_LO = 6;
  localparam int A_SIZE_HI = 7;

  localparam int CAUSE_W = 6;
  localparam logic [CAUSE_W-1:0] CAUSE_PROT = 6'h23;

  typedef enum logic [1:0] {
    PG_1K = 2'd0,
    PG_4K = 2'd1,
    PG_1M = 2'd2,
    PG_4M = 2'd3
  } page_size_e;

  // number of page-offset bits for a size code
  function automatic int page_shift(input logic [1:0] code);
    case (page_size_e'(code))
      PG_1K:   page_shift = 10;
      PG_4K:   page_shift = 12;
      PG_1M:   page_shift = 20;
      default: page_shift = 22;
    endcase
  endfunction

endpackage

// File: rtl/dprot_regs.sv
module dprot_regs
  import dprot_pkg::*;
#(
  parameter int N_ENT  = 16,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int IDX_W  = $clog2(N_ENT),
  localparam int CFG_AW = IDX_W + 2,
  localparam int STAT_W = N_ENT + 3
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          cfg_we,
  input  logic [CFG_AW-1:0]             cfg_addr,
  input  logic [DATA_W-1:0]             cfg_wdata,
  output logic [DATA_W-1:0]             cfg_rdata,
  input  logic [ADDR_W-1:0]             fault_addr,
  input  logic [STAT_W-1:0]             fault_stat,
  output logic [N_ENT-1:0][ADDR_W-1:0]  base_q,
  output logic [N_ENT-1:0][ATTR_W-1:0]  attr_q,
  output logic                          enable_q
);

  localparam logic [1:0] RG_BASE = 2'd0;
  localparam logic [1:0] RG_ATTR = 2'd1;
  localparam logic [1:0] RG_MISC = 2'd2;
  localparam logic [IDX_W-1:0] MS_CTRL = IDX_W'(0);
  localparam logic [IDX_W-1:0] MS_FADR = IDX_W'(1);
  localparam logic [IDX_W-1:0] MS_FSTA = IDX_W'(2);

  logic [1:0]        region;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] rd_mux;

  assign region = cfg_addr[CFG_AW-1:IDX_W];
  assign idx    = cfg_addr[IDX_W-1:0];

  for (genvar g = 0; g < N_ENT; g++) begin : g_ent
    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(g);
    always_ff @(posedge clk) begin
      if (rst) begin
        base_q[g] <= '0;
        attr_q[g] <= '0;
      end else if (cfg_we && idx == MY_IDX) begin
        if (region == RG_BASE) base_q[g] <= cfg_wdata[ADDR_W-1:0];
        if (region == RG_ATTR) attr_q[g] <= cfg_wdata[ATTR_W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      enable_q <= 1'b0;
    end else if (cfg_we && region == RG_MISC && idx == MS_CTRL) begin
      enable_q <= cfg_wdata[0];
    end
  end

  always_comb begin
    rd_mux = '0;
    case (region)
      RG_BASE: rd_mux = DATA_W'(base_q[idx]);
      RG_ATTR: rd_mux = DATA_W'(attr_q[idx]);
      RG_MISC: begin
        if (idx == MS_CTRL) rd_mux = DATA_W'(enable_q);
        if (idx == MS_FADR) rd_mux = DATA_W'(fault_addr);
        if (idx == MS_FSTA) rd_mux = DATA_W'(fault_stat);
      end
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) cfg_rdata <= '0;
    else     cfg_rdata <= rd_mux;
  end

  // R12
  ctrl_write_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && region == RG_MISC && idx == MS_CTRL) |=> (enable_q == $past(cfg_wdata[0])));

endmodule

// File: rtl/dprot_match.sv
module dprot_match
  import dprot_pkg::*;
#(
  parameter int N_ENT  = 16,
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0]             acc_addr,
  input  logic [N_ENT-1:0][ADDR_W-1:0]  base_q,
  input  logic [N_ENT-1:0][ATTR_W-1:0]  attr_q,
  output logic [N_ENT-1:0]              hit_vec,
  output logic [ATTR_W-1:0]             sel_attr
);

  for (genvar g = 0; g < N_ENT; g++) begin : g_cmp
    logic [ADDR_W-1:0] mask;
    assign mask       = {ADDR_W{1'b1}} << page_shift(attr_q[g][A_SIZE_HI:A_SIZE_LO]);
    assign hit_vec[g] = attr_q[g][A_VALID] && (((acc_addr ^ base_q[g]) & mask) == '0);
  end

  // one-hot select of the matching attribute byte
  always_comb begin
    sel_attr = '0;
    for (int i = 0; i < N_ENT; i++) begin
      if (hit_vec[i]) sel_attr = sel_attr | attr_q[i];
    end
  end

endmodule

// File: rtl/dprot_eval.sv
module dprot_eval
  import dprot_pkg::*;
#(
  parameter int N_ENT = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                acc_valid,
  input  logic                acc_write,
  input  logic                acc_supv,
  input  logic                acc_gen,
  input  logic                enable,
  input  logic [N_ENT-1:0]    hit_vec,
  input  logic [ATTR_W-1:0]   sel_attr,
  output logic                fault,
  output logic                miss,
  output logic [CAUSE_W-1:0]  cause
);

  logic active, single, perm_bad, dirty_bad, gen_bad;

  assign active = acc_valid && enable;
  assign single = ($countones(hit_vec) == 1);

  always_comb begin
    if (acc_write) perm_bad = acc_supv ? !sel_attr[A_SWRITE] : !sel_attr[A_URW];
    else           perm_bad = acc_supv ? 1'b0 : !(sel_attr[A_UREAD] || sel_attr[A_URW]);
  end

  assign dirty_bad = acc_write && !sel_attr[A_DIRTY];
  assign gen_bad   = sel_attr[A_GEN0] && acc_gen;

  assign fault = active && single && (perm_bad || dirty_bad || gen_bad);
  assign miss  = active && !single;
  assign cause = fault ? CAUSE_PROT : '0;

  // R7
  cause_code_chk: assert property (@(posedge clk) disable iff (rst)
    fault |-> (cause == 6'h23));

  // R11
  off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !enable |-> (!fault && !miss));

  // R5
  clean_write_chk: assert property (@(posedge clk) disable iff (rst)
    (active && single && acc_write && !sel_attr[A_DIRTY]) |-> fault);

endmodule

// File: rtl/dprot_fault_log.sv
module dprot_fault_log #(
  parameter int N_ENT  = 16,
  parameter int ADDR_W = 32,
  localparam int STAT_W = N_ENT + 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               fault,
  input  logic [ADDR_W-1:0]  acc_addr,
  input  logic               acc_write,
  input  logic               acc_supv,
  input  logic               acc_gen,
  input  logic [N_ENT-1:0]   hit_vec,
  output logic [ADDR_W-1:0]  fault_addr,
  output logic [STAT_W-1:0]  fault_stat
);

  always_ff @(posedge clk) begin
    if (rst) begin
      fault_addr <= '0;
      fault_stat <= '0;
    end else if (fault) begin
      fault_addr <= acc_addr;
      fault_stat <= {acc_supv, acc_gen, acc_write, hit_vec};
    end
  end

  // R8
  fault_addr_chk: assert property (@(posedge clk) disable iff (rst)
    fault |=> (fault_addr == $past(acc_addr)));

  // R8
  fault_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !fault |=> ($stable(fault_addr) && $stable(fault_stat)));

  // R9
  stat_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    fault |=> ($countones(fault_stat[N_ENT-1:0]) == 1));

endmodule

// File: rtl/dprot_checker.sv
module dprot_checker
  import dprot_pkg::*;
#(
  parameter int N_ENT  = 16,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        cfg_we,
  input  logic [$clog2(N_ENT)+1:0]    cfg_addr,
  input  logic [DATA_W-1:0]           cfg_wdata,
  output logic [DATA_W-1:0]           cfg_rdata,
  input  logic                        acc_valid,
  input  logic [ADDR_W-1:0]           acc_addr,
  input  logic                        acc_write,
  input  logic                        acc_supv,
  input  logic                        acc_gen,
  output logic                        acc_fault,
  output logic [CAUSE_W-1:0]          acc_cause,
  output logic                        acc_miss
);

  localparam int STAT_W = N_ENT + 3;

  logic [N_ENT-1:0][ADDR_W-1:0] base_q;
  logic [N_ENT-1:0][ATTR_W-1:0] attr_q;
  logic                         enable_q;
  logic [N_ENT-1:0]             hit_vec;
  logic [ATTR_W-1:0]            sel_attr;
  logic [ADDR_W-1:0]            fault_addr;
  logic [STAT_W-1:0]            fault_stat;

  dprot_regs #(.N_ENT(N_ENT), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .fault_addr(fault_addr), .fault_stat(fault_stat),
    .base_q(base_q), .attr_q(attr_q), .enable_q(enable_q)
  );

  dprot_match #(.N_ENT(N_ENT), .ADDR_W(ADDR_W)) u_match (
    .acc_addr(acc_addr), .base_q(base_q), .attr_q(attr_q),
    .hit_vec(hit_vec), .sel_attr(sel_attr)
  );

  dprot_eval #(.N_ENT(N_ENT)) u_eval (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_supv(acc_supv), .acc_gen(acc_gen), .enable(enable_q),
    .hit_vec(hit_vec), .sel_attr(sel_attr),
    .fault(acc_fault), .miss(acc_miss), .cause(acc_cause)
  );

  dprot_fault_log #(.N_ENT(N_ENT), .ADDR_W(ADDR_W)) u_log (
    .clk(clk), .rst(rst), .fault(acc_fault), .acc_addr(acc_addr),
    .acc_write(acc_write), .acc_supv(acc_supv), .acc_gen(acc_gen),
    .hit_vec(hit_vec), .fault_addr(fault_addr), .fault_stat(fault_stat)
  );

  // R10
  miss_excl_chk: assert property (@(posedge clk) disable iff (rst)
    acc_miss |-> !acc_fault);

  // R10
  miss_nolog_chk: assert property (@(posedge clk) disable iff (rst)
    acc_miss |=> $stable(fault_addr));

endmodule

// File: tb/dprot_checker_bench.sv
module dprot_checker_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [5:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        acc_valid = 1'b0;
  logic [31:0] acc_addr = '0;
  logic        acc_write = 1'b0;
  logic        acc_supv = 1'b0;
  logic        acc_gen = 1'b0;
  logic        acc_fault;
  logic [5:0]  acc_cause;
  logic        acc_miss;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dprot_checker u_dprot_checker (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .acc_valid(acc_valid),
    .acc_addr(acc_addr), .acc_write(acc_write), .acc_supv(acc_supv),
    .acc_gen(acc_gen), .acc_fault(acc_fault), .acc_cause(acc_cause),
    .acc_miss(acc_miss)
  );

  // {addr, write, supv, gen, exp_fault, exp_miss}
  localparam int NV = 22;
  localparam logic [36:0] VEC [0:NV-1] = '{
    {32'h0000_0804, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
    {32'h0000_0804, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},
    {32'h0000_1010, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    {32'h0000_1010, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},
    {32'h0000_2000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
    {32'h0000_2000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
    {32'h0000_3000, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},
    {32'h0000_3000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    {32'h0000_4000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    {32'h0000_4000, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0},
    {32'h0000_43FC, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0},
    {32'hFFC1_2340, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
    {32'hFFFF_FFFC, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
    {32'hFFC0_0000, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},
    {32'h0000_6FFC, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    {32'h0000_6FFC, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},
    {32'h0000_7000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1},
    {32'h0000_5000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1},
    {32'h0000_0BFC, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
    {32'h0000_0C00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1},
    {32'h001F_FFFC, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
    {32'h0020_0000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1}
  };

  function automatic string vtag(input int i);
    case (i)
      0, 5, 15:             vtag = "R2";
      1, 3, 13:             vtag = "R3";
      2, 4:                 vtag = "R4";
      6, 7:                 vtag = "R5";
      8, 9, 10:             vtag = "R6";
      16, 17:               vtag = "R10";
      default:              vtag = "R1";
    endcase
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_read(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_addr = a;
    @(negedge clk);
    d = cfg_rdata;
  endtask

  // presents one access for one clock edge, sampling outputs before the edge
  task automatic access(input logic [31:0] a, input logic w, input logic s,
                        input logic g, output logic f, output logic m,
                        output logic [5:0] c);
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = a; acc_write = w; acc_supv = s; acc_gen = g;
    #1;
    f = acc_fault; m = acc_miss; c = acc_cause;
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] rd;
    logic f, m;
    logic [5:0] c;

    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R12: reset state
    cfg_read(6'h20, rd); check("R12", "ctrl after reset", rd, 32'h0);
    cfg_read(6'h10, rd); check("R12", "attr0 after reset", rd, 32'h0);
    access(32'h0000_0804, 1'b1, 1'b0, 1'b0, f, m, c);
    check("R11", "fault while disabled after reset", {31'b0, f}, 32'h0);

    // table setup
    cfg_write(6'h00, 32'h0000_0800); cfg_write(6'h10, 32'h19);
    cfg_write(6'h01, 32'h0000_1000); cfg_write(6'h11, 32'h1B);
    cfg_write(6'h02, 32'h0000_2000); cfg_write(6'h12, 32'h19);
    cfg_write(6'h03, 32'h0000_3000); cfg_write(6'h13, 32'h0D);
    cfg_write(6'h04, 32'h0000_4000); cfg_write(6'h14, 32'h3D);
    cfg_write(6'h05, 32'hFFC0_0000); cfg_write(6'h15, 32'hD9);
    cfg_write(6'h06, 32'h0000_6000); cfg_write(6'h16, 32'h55);
    cfg_write(6'h07, 32'h0000_5000); cfg_write(6'h17, 32'h1C);
    cfg_write(6'h08, 32'h0010_0000); cfg_write(6'h18, 32'h99);
    cfg_write(6'h20, 32'h1);

    // R12: readback
    cfg_read(6'h14, rd); check("R12", "attr4 readback", rd, 32'h3D);
    cfg_read(6'h05, rd); check("R12", "base5 readback", rd, 32'hFFC0_0000);
    cfg_read(6'h20, rd); check("R12", "ctrl readback", rd, 32'h1);

    // vector walk
    for (int i = 0; i < NV; i++) begin
      access(VEC[i][36:5], VEC[i][4], VEC[i][3], VEC[i][2], f, m, c);
      check(vtag(i), $sformatf("vector %0d fault", i), {31'b0, f}, {31'b0, VEC[i][1]});
      check(vtag(i), $sformatf("vector %0d miss", i), {31'b0, m}, {31'b0, VEC[i][0]});
      check("R7", $sformatf("vector %0d cause", i), {26'b0, c}, VEC[i][1] ? 32'h23 : 32'h0);
    end

    // R8 R9: user write from generator 1 to entry 1
    access(32'h0000_1010, 1'b1, 1'b0, 1'b1, f, m, c);
    cfg_read(6'h21, rd); check("R8", "fault addr user write", rd, 32'h0000_1010);
    cfg_read(6'h22, rd); check("R9", "status user write gen1", rd, 32'h0003_0002);

    access(32'h0000_2000, 1'b0, 1'b0, 1'b0, f, m, c);
    cfg_read(6'h22, rd); check("R9", "status user read", rd, 32'h0000_0004);

    access(32'h0000_3000, 1'b1, 1'b1, 1'b0, f, m, c);
    cfg_read(6'h21, rd); check("R8", "fault addr supv write", rd, 32'h0000_3000);
    cfg_read(6'h22, rd); check("R9", "status supv write", rd, 32'h0005_0008);

    // R8: hold across passing accesses and a faulting pattern with valid low
    access(32'h0000_0804, 1'b1, 1'b1, 1'b0, f, m, c);
    @(negedge clk);
    acc_addr = 32'h0000_0804; acc_write = 1'b1; acc_supv = 1'b0; acc_valid = 1'b0;
    #1 check("R8", "no fault with valid low", {31'b0, acc_fault}, 32'h0);
    @(negedge clk);
    cfg_read(6'h21, rd); check("R8", "fault addr held", rd, 32'h0000_3000);

    // R10: overlapping 4 KB page over entry 0
    cfg_write(6'h09, 32'h0000_0000); cfg_write(6'h19, 32'h5D);
    access(32'h0000_0804, 1'b1, 1'b0, 1'b0, f, m, c);
    check("R10", "multi-hit miss", {31'b0, m}, 32'h1);
    check("R10", "multi-hit no fault", {31'b0, f}, 32'h0);
    cfg_read(6'h21, rd); check("R10", "multi-hit leaves fault addr", rd, 32'h0000_3000);
    cfg_write(6'h19, 32'h0);

    // R11: disable
    cfg_write(6'h20, 32'h0);
    access(32'h0000_0804, 1'b1, 1'b0, 1'b0, f, m, c);
    check("R11", "disabled no fault", {31'b0, f}, 32'h0);
    access(32'h0000_7000, 1'b0, 1'b1, 1'b0, f, m, c);
    check("R11", "disabled no miss", {31'b0, m}, 32'h0);

    // R12: reset clears everything
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    cfg_read(6'h10, rd); check("R12", "attr0 cleared", rd, 32'h0);
    cfg_read(6'h04, rd); check("R12", "base4 cleared", rd, 32'h0);
    cfg_read(6'h21, rd); check("R12", "fault addr cleared", rd, 32'h0);
    cfg_read(6'h22, rd); check("R12", "status cleared", rd, 32'h0);
    cfg_read(6'h20, rd); check("R12", "ctrl cleared", rd, 32'h0);

    finish_run();
  end

endmodule